// File: doc/BRIEF.md
# Byte and Pair Register File with Pointer Unit

This block is the general register storage of a small 8-bit processor datapath. It holds six programmer-visible byte registers and two hidden byte temporaries. The same storage can be read and written one byte at a time through a 3-bit select, or as 16-bit pairs through a 2-bit select. In each pair the first-named register is the high byte. The hidden pair is used by a three-cycle sequence that swaps the second and third visible pairs.

Next to the byte storage sit a 16-bit program counter and a 16-bit stack pointer. A single shared add-one / subtract-one unit updates whichever of the two the pointer command names. Either pointer can also be loaded directly. The stack pointer is pre-decremented for a push and post-incremented for a pop, so it always addresses the most recently pushed byte. Instruction decode, memory and the ALU sit outside the block and drive its ports.

Top module: `regpair_file`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `pc` reads 0000h and `xchg_busy` reads 0.
- R2: The byte select codes are B=0, C=1, D=2, E=3, H=4 and L=5. `rd8_data` shows the selected register combinationally. A write with `wr8_en` becomes visible after the next rising clock edge.
- R3: A byte write with select code 6 or 7 changes no register. A byte read with code 6 or 7 returns 00h.
- R4: The pair select codes are BC=0, DE=1, HL=2 and WZ=3. In each pair the first-named register is bits 15:8. A pair write updates both bytes on the next edge, and a pair read returns both bytes combinationally.
- R5: If a byte write and a pair write touch the same register in one cycle, that register takes the byte-write value. The other byte of the pair takes the pair-write value.
- R6: When `xchg_start` is sampled while the block is idle, three consecutive edges run the exchange: WZ←DE, then DE←HL, then HL←WZ. `xchg_busy` is 1 for the two cycles after the starting edge. Once it drops, DE holds the old HL, HL holds the old DE and WZ holds the old DE.
- R7: In the start cycle and while `xchg_busy` is 1, byte writes and pair writes are ignored, and a further `xchg_start` is ignored.
- R8: The pointer command codes are 0 hold, 1 PC+1, 2 PC←`ptr_load`, 3 SP−1 (push), 4 SP+1 (pop), 5 SP←`ptr_load`, and 6 or 7 hold. Each command takes effect at the next edge. Increment and decrement wrap modulo 65536.
- R9: Each pointer command changes at most one pointer. The pointer it does not name keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd8_sel | input | 3 | Byte read select |
| rd8_data | output | 8 | Byte read data |
| rd16_sel | input | 2 | Pair read select |
| rd16_data | output | 16 | Pair read data |
| wr8_en | input | 1 | Byte write enable |
| wr8_sel | input | 3 | Byte write select |
| wr8_data | input | 8 | Byte write data |
| wr16_en | input | 1 | Pair write enable |
| wr16_sel | input | 2 | Pair write select |
| wr16_data | input | 16 | Pair write data |
| xchg_start | input | 1 | Start DE/HL exchange |
| xchg_busy | output | 1 | Exchange in progress |
| ptr_op | input | 3 | Pointer command |
| ptr_load | input | 16 | Pointer load value |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |

## Verification
A corrupted byte register shows up on `rd8_data` or `rd16_data` as soon as its code is selected, because both read paths are combinational. An exchange with a wrong step order leaves DE, HL or WZ holding a wrong value in the first cycle after `xchg_busy` falls. A wrong exchange state shows up one cycle earlier as a busy flag of the wrong length. A pointer fault, such as the wrong operand reaching the shared adder or a wrong direction, appears on `pc` or `sp` one edge after the command.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

    typedef enum logic [2:0] {
        PTR_HOLD    = 3'd0,
        PTR_PC_INC  = 3'd1,
        PTR_PC_LOAD = 3'd2,
        PTR_SP_DEC  = 3'd3,
        PTR_SP_INC  = 3'd4,
        PTR_SP_LOAD = 3'd5
    } ptr_op_e;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_DE   = 2'd1,
        XS_HL   = 2'd2
    } xchg_state_e;

    localparam int unsigned NUM_VISIBLE = 6;
    localparam int unsigned NUM_BYTES   = 8;

endpackage

// File: rtl/rpf_xchg_seq.sv
module rpf_xchg_seq
    import rpf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic step_wz,
    output logic step_de,
    output logic step_hl,
    output logic busy
);

    typedef struct packed {
        xchg_state_e st;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        step_wz = 1'b0;
        step_de = 1'b0;
        step_hl = 1'b0;
        unique case (s_q.st)
            XS_IDLE: if (start) begin
                step_wz = 1'b1;
                s_d.st  = XS_DE;
            end
            XS_DE: begin
                step_de = 1'b1;
                s_d.st  = XS_HL;
            end
            XS_HL: begin
                step_hl = 1'b1;
                s_d.st  = XS_IDLE;
            end
            default: s_d.st = XS_IDLE;
        endcase
    end

    assign busy = (s_q.st != XS_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: XS_IDLE};
        else        s_q <= s_d;
    end

    // R6: the three steps never overlap
    a_r6_steps_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_wz, step_de, step_hl}));
    // R6: an accepted start leads to busy on the next cycle
    a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R6: the DE step is always followed by the HL step
    a_r6_de_then_hl: assert property (@(posedge clk) disable iff (!rst_n)
        step_de |=> step_hl);

endmodule

// File: rtl/rpf_byte_bank.sv
module rpf_byte_bank
    import rpf_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock,
    input  logic          step_wz,
    input  logic          step_de,
    input  logic          step_hl,
    input  logic          wr8_en,
    input  logic [2:0]    wr8_sel,
    input  logic [DW-1:0] wr8_data,
    input  logic          wr16_en,
    input  logic [1:0]    wr16_sel,
    input  logic [2*DW-1:0] wr16_data,
    input  logic [2:0]    rd8_sel,
    output logic [DW-1:0] rd8_data,
    input  logic [1:0]    rd16_sel,
    output logic [2*DW-1:0] rd16_data
);

    localparam int unsigned IB = 0, IC = 1, ID = 2, IE = 3, IH = 4, IL = 5, IW = 6, IZ = 7;

    typedef struct packed {
        logic [NUM_BYTES-1:0][DW-1:0] r;
    } bank_t;

    bank_t b_d, b_q;

    logic [2:0] pair_hi, pair_lo, rd_hi, rd_lo;

    always_comb begin
        pair_hi = {wr16_sel, 1'b0};
        pair_lo = {wr16_sel, 1'b1};
        b_d     = b_q;
        if (step_wz) begin
            b_d.r[IW] = b_q.r[ID];
            b_d.r[IZ] = b_q.r[IE];
        end else if (step_de) begin
            b_d.r[ID] = b_q.r[IH];
            b_d.r[IE] = b_q.r[IL];
        end else if (step_hl) begin
            b_d.r[IH] = b_q.r[IW];
            b_d.r[IL] = b_q.r[IZ];
        end else if (!lock) begin
            if (wr16_en) begin
                b_d.r[pair_hi] = wr16_data[2*DW-1:DW];
                b_d.r[pair_lo] = wr16_data[DW-1:0];
            end
            if (wr8_en && (32'(wr8_sel) < NUM_VISIBLE)) begin
                b_d.r[wr8_sel] = wr8_data;
            end
        end
    end

    always_comb begin
        rd_hi     = {rd16_sel, 1'b0};
        rd_lo     = {rd16_sel, 1'b1};
        rd8_data  = (32'(rd8_sel) < NUM_VISIBLE) ? b_q.r[rd8_sel] : '0;
        rd16_data = {b_q.r[rd_hi], b_q.r[rd_lo]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    // R3: a write to code 6 or 7 alone leaves the whole bank untouched
    a_r3_bad_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr8_en && wr8_sel > 3'd5 && !wr16_en && !lock) |=> $stable(b_q));
    // R7: during an exchange the BC pair cannot change
    a_r7_lock_holds_bc: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(b_q.r[IB]) && $stable(b_q.r[IC])));
    // R6: the DE step loads DE from the HL value of the cycle before
    a_r6_de_from_hl: assert property (@(posedge clk) disable iff (!rst_n)
        step_de |=> ({b_q.r[ID], b_q.r[IE]} == $past({b_q.r[IH], b_q.r[IL]})));
    // R6: the HL step loads HL from WZ
    a_r6_hl_from_wz: assert property (@(posedge clk) disable iff (!rst_n)
        step_hl |=> ({b_q.r[IH], b_q.r[IL]} == $past({b_q.r[IW], b_q.r[IZ]})));

endmodule

// File: rtl/rpf_ptr_unit.sv
module rpf_ptr_unit
    import rpf_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    ptr_op,
    input  logic [AW-1:0] ptr_load,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] sp
);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
    } ptr_t;

    ptr_t p_d, p_q;

    logic          use_sp, go_down;
    logic [AW-1:0] operand, stepped;

    // shared add-one / subtract-one unit
    always_comb begin
        use_sp  = (ptr_op == PTR_SP_DEC) || (ptr_op == PTR_SP_INC);
        go_down = (ptr_op == PTR_SP_DEC);
        operand = use_sp ? p_q.sp : p_q.pc;
        stepped = operand + (go_down ? {AW{1'b1}} : AW'(1));
    end

    always_comb begin
        p_d = p_q;
        case (ptr_op)
            PTR_PC_INC:  p_d.pc = stepped;
            PTR_PC_LOAD: p_d.pc = ptr_load;
            PTR_SP_DEC,
            PTR_SP_INC:  p_d.sp = stepped;
            PTR_SP_LOAD: p_d.sp = ptr_load;
            default:     p_d = p_q;
        endcase
    end

    assign pc = p_q.pc;
    assign sp = p_q.sp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // R8: program counter increments by one with wrap
    a_r8_pc_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_op == 3'd1) |=> (p_q.pc == $past(p_q.pc) + AW'(1)));
    // R8: push lowers the stack pointer by one
    a_r8_sp_push: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_op == 3'd3) |=> (p_q.sp == $past(p_q.sp) - AW'(1)));
    // R8: pop raises the stack pointer by one
    a_r8_sp_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_op == 3'd4) |=> (p_q.sp == $past(p_q.sp) + AW'(1)));
    // R9: stack commands leave the program counter alone
    a_r9_sp_ops_keep_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_op >= 3'd3) |=> $stable(p_q.pc));
    // R9: program counter commands leave the stack pointer alone
    a_r9_pc_ops_keep_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_op == 3'd1 || ptr_op == 3'd2) |=> $stable(p_q.sp));

endmodule

// File: rtl/regpair_file.sv
module regpair_file
    import rpf_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    rd8_sel,
    output logic [DW-1:0] rd8_data,
    input  logic [1:0]    rd16_sel,
    output logic [2*DW-1:0] rd16_data,
    input  logic          wr8_en,
    input  logic [2:0]    wr8_sel,
    input  logic [DW-1:0] wr8_data,
    input  logic          wr16_en,
    input  logic [1:0]    wr16_sel,
    input  logic [2*DW-1:0] wr16_data,
    input  logic          xchg_start,
    output logic          xchg_busy,
    input  logic [2:0]    ptr_op,
    input  logic [AW-1:0] ptr_load,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] sp
);

    logic step_wz, step_de, step_hl, lock;

    rpf_xchg_seq i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (xchg_start),
        .step_wz (step_wz),
        .step_de (step_de),
        .step_hl (step_hl),
        .busy    (xchg_busy)
    );

    assign lock = xchg_start | xchg_busy;

    rpf_byte_bank #(.DW(DW)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (lock),
        .step_wz   (step_wz),
        .step_de   (step_de),
        .step_hl   (step_hl),
        .wr8_en    (wr8_en),
        .wr8_sel   (wr8_sel),
        .wr8_data  (wr8_data),
        .wr16_en   (wr16_en),
        .wr16_sel  (wr16_sel),
        .wr16_data (wr16_data),
        .rd8_sel   (rd8_sel),
        .rd8_data  (rd8_data),
        .rd16_sel  (rd16_sel),
        .rd16_data (rd16_data)
    );

    rpf_ptr_unit #(.AW(AW)) i_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_op   (ptr_op),
        .ptr_load (ptr_load),
        .pc       (pc),
        .sp       (sp)
    );

    // R1: program counter is zero while reset is applied
    a_r1_pc_reset: assert property (@(posedge clk) !rst_n |-> (pc == '0 && !xchg_busy));

endmodule

// File: tb/test_regpair_file.sv
module test_regpair_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd8_sel = '0;
    logic [7:0]  rd8_data;
    logic [1:0]  rd16_sel = '0;
    logic [15:0] rd16_data;
    logic        wr8_en = 1'b0;
    logic [2:0]  wr8_sel = '0;
    logic [7:0]  wr8_data = '0;
    logic        wr16_en = 1'b0;
    logic [1:0]  wr16_sel = '0;
    logic [15:0] wr16_data = '0;
    logic        xchg_start = 1'b0;
    logic        xchg_busy;
    logic [2:0]  ptr_op = '0;
    logic [15:0] ptr_load = '0;
    logic [15:0] pc, sp;

    regpair_file i_regpair_file (
        .clk(clk), .rst_n(rst_n),
        .rd8_sel(rd8_sel), .rd8_data(rd8_data),
        .rd16_sel(rd16_sel), .rd16_data(rd16_data),
        .wr8_en(wr8_en), .wr8_sel(wr8_sel), .wr8_data(wr8_data),
        .wr16_en(wr16_en), .wr16_sel(wr16_sel), .wr16_data(wr16_data),
        .xchg_start(xchg_start), .xchg_busy(xchg_busy),
        .ptr_op(ptr_op), .ptr_load(ptr_load), .pc(pc), .sp(sp)
    );

    always #5 clk = ~clk;

    // scoreboard item: port 0 byte read, 1 pair read, 2 pc, 3 sp, 4 busy
    typedef struct {
        int          port;
        logic [15:0] val;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model: index 0..5 B..L, 6 W, 7 Z
    logic [7:0]  m[8];
    logic [15:0] mpc, msp;

    // monitor: compare just after each rising edge
    always begin
        @(posedge clk);
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.port)
                0:       act = {8'h00, rd8_data};
                1:       act = rd16_data;
                2:       act = pc;
                3:       act = sp;
                default: act = {15'd0, xchg_busy};
            endcase
            checks++;
            if (act !== it.val) begin
                errors++;
                $display("FAIL %s port %0d actual %h expected %h", it.tag, it.port, act, it.val);
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_ctl();
        wr8_en = 0; wr16_en = 0; xchg_start = 0; ptr_op = 3'd0;
    endtask

    task automatic push(int port, logic [15:0] v, string tag);
        item_t it;
        it.port = port; it.val = v; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr8(logic [2:0] s, logic [7:0] v);
        wr8_en = 1; wr8_sel = s; wr8_data = v;
        if (s < 3'd6) m[s] = v;
        step(); idle_ctl();
    endtask

    task automatic wr16(logic [1:0] s, logic [15:0] v);
        wr16_en = 1; wr16_sel = s; wr16_data = v;
        m[{s, 1'b0}] = v[15:8]; m[{s, 1'b1}] = v[7:0];
        step(); idle_ctl();
    endtask

    task automatic ptr(logic [2:0] op, logic [15:0] ld);
        ptr_op = op; ptr_load = ld;
        case (op)
            3'd1: mpc = mpc + 16'd1;
            3'd2: mpc = ld;
            3'd3: msp = msp - 16'd1;
            3'd4: msp = msp + 16'd1;
            3'd5: msp = ld;
            default: ;
        endcase
        step(); idle_ctl();
    endtask

    task automatic exp8(logic [2:0] s, string tag);
        rd8_sel = s;
        push(0, {8'h00, (s < 3'd6) ? m[s] : 8'h00}, tag);
        step();
    endtask

    task automatic exp16(logic [1:0] s, string tag);
        rd16_sel = s;
        push(1, {m[{s, 1'b0}], m[{s, 1'b1}]}, tag);
        step();
    endtask

    task automatic exp_ptrs(string tag);
        push(2, mpc, tag);
        push(3, msp, tag);
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m[i] = 8'h00;
        mpc = 16'h0000; msp = 16'h0000;
        repeat (3) step();
        rst_n = 1;
        // R1: reset values
        push(2, 16'h0000, "R1");
        push(4, 16'h0000, "R1");
        step();

        // R2: every visible byte register by code
        for (int i = 0; i < 6; i++) wr8(3'(i), 8'(8'h11 * (i + 1)));
        for (int i = 0; i < 6; i++) exp8(3'(i), "R2");

        // R3: codes 6 and 7 write nothing and read zero
        wr16(2'd3, 16'h1234);
        wr8(3'd6, 8'hAA);
        wr8(3'd7, 8'hBB);
        exp16(2'd3, "R3");
        exp8(3'd6, "R3");
        exp8(3'd7, "R3");
        for (int i = 0; i < 3; i++) exp16(2'(i), "R3");

        // R4: pair write then byte reads and pair reads
        wr16(2'd2, 16'hABCD);
        exp8(3'd4, "R4");
        exp8(3'd5, "R4");
        exp16(2'd0, "R4");
        exp16(2'd2, "R4");

        // R5: byte write wins over pair write on the same register
        wr16_en = 1; wr16_sel = 2'd1; wr16_data = 16'h0F0E;
        wr8_en = 1; wr8_sel = 3'd3; wr8_data = 8'h77;
        m[2] = 8'h0F; m[3] = 8'h77;
        step(); idle_ctl();
        exp16(2'd1, "R5");

        // R6 and R7: exchange with writes and a second start while busy
        xchg_start = 1;
        wr16_en = 1; wr16_sel = 2'd0; wr16_data = 16'hDEAD;
        step();
        idle_ctl();
        xchg_start = 1;
        wr8_en = 1; wr8_sel = 3'd0; wr8_data = 8'h99;
        push(4, 16'h0001, "R6");
        step();
        idle_ctl();
        push(4, 16'h0000, "R6");
        step();
        begin
            logic [7:0] d0, e0;
            d0 = m[2]; e0 = m[3];
            m[6] = d0; m[7] = e0;
            m[2] = m[4]; m[3] = m[5];
            m[4] = d0; m[5] = e0;
        end
        exp16(2'd1, "R6");
        exp16(2'd2, "R6");
        exp16(2'd3, "R6");
        exp16(2'd0, "R7");
        exp8(3'd0, "R7");
        push(4, 16'h0000, "R7");
        step();

        // R8 and R9: pointer commands, wrap, hold codes
        ptr(3'd2, 16'h00FE);
        ptr(3'd1, 16'h0000);
        ptr(3'd1, 16'h0000);
        exp_ptrs("R8");
        ptr(3'd2, 16'hFFFF);
        ptr(3'd1, 16'h0000);
        exp_ptrs("R8");
        ptr(3'd5, 16'h0001);
        ptr(3'd3, 16'h0000);
        ptr(3'd3, 16'h0000);
        exp_ptrs("R9");
        ptr(3'd4, 16'h0000);
        exp_ptrs("R8");
        ptr(3'd6, 16'h5555);
        ptr(3'd7, 16'h5555);
        ptr(3'd0, 16'h5555);
        exp_ptrs("R8");

        step();
        step();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule